// File: doc/BRIEF.md
# Fully associative page translation buffer

This block keeps a small set of recently used page translations for a 32-bit virtual address space with 4 KiB pages. A requester presents a virtual address and an access kind (read, write or instruction fetch). Every stored entry is compared against the page number at the same time. The lookup ends in one of three ways, reported in the same cycle: a hit with a physical address, a protection fault, or a miss. A hit updates the entry's usage bits at the next clock edge.

Each entry holds a page number, a frame number, three permission bits, and valid, referenced and modified flags. An outside page-table walker answers misses through a refill port. The refill port places a translation in a free slot, or in the slot that already holds that page. When no slot is free it evicts a slot chosen in rotation. A flush input empties the whole buffer in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: The page number is vaddr[31:12] and the offset is vaddr[11:0]. On a hit, paddr equals {stored frame, offset} in the same cycle as the request.
- R2: A translation can sit in any slot, and every slot is searched on every lookup. All slots give the same result for the same stored contents.
- R3: A slot whose valid flag is clear never matches. After reset no slot is valid, so every lookup misses.
- R4: The permission bits given at refill are bit0 readable, bit1 writable and bit2 executable. The access kind encoding is 0 read, 1 write, 2 fetch and 3 reserved. An access whose kind is not allowed, or whose kind is 3, raises prot_fault with hit low and paddr zero.
- R5: While lookup_valid is high, exactly one of hit, miss and prot_fault is high. While lookup_valid is low, all three are low.
- R6: A hit sets the slot's referenced flag, and a write hit also sets its modified flag. A faulting access changes neither flag. entry_ref and entry_mod show the slot's flags as they stood before the current access. A refill clears both flags.
- R7: On a miss, miss_vpn takes the page number at the next clock edge. It then holds that value until the next miss.
- R8: A refill of a page that is not present goes into the lowest-numbered slot that is not valid.
- R9: When every slot is valid, a refill of a new page replaces the slot named by a rotating pointer. The pointer starts at 0 after reset and moves forward by one, modulo the slot count, after each such replacement. Flushes and refills of a page already present leave the pointer where it is.
- R10: A refill of a page that is already present overwrites that slot's frame and permissions. Every other slot stays untouched.
- R11: A flush clears every valid flag in one cycle. When a flush and a refill arrive in the same cycle, the flush wins and the refill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Invalidate every slot |
| lookup_valid | input | 1 | A lookup request is present |
| lookup_vaddr | input | 32 | Virtual address to translate |
| lookup_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| hit | output | 1 | Translation found and access allowed |
| miss | output | 1 | No valid slot holds the page |
| prot_fault | output | 1 | Page found but the access kind is not allowed |
| paddr | output | 32 | Physical address on a hit, zero otherwise |
| entry_ref | output | 1 | Referenced flag of the hit slot before this access |
| entry_mod | output | 1 | Modified flag of the hit slot before this access |
| miss_vpn | output | 20 | Page number of the most recent miss |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Page number to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_perm | input | 3 | Permissions to install (bit0 R, bit1 W, bit2 X) |

## Verification
The properties assume that no lookup arrives during the two cycles in which the internal reset synchronizer is still releasing. They also assume that the requester never relies on a lookup and a refill of the same page in the same cycle. The stimulus waits several cycles after reset before its first request, and it never drives a lookup and a refill in the same cycle. Only the flush-with-refill case deliberately overlaps two inputs, and no lookup is active in that cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  function automatic logic access_ok(acc_kind_e kind, logic [2:0] perm);
    logic ok;
    case (kind)
      ACC_READ:  ok = perm[PERM_R];
      ACC_WRITE: ok = perm[PERM_W];
      ACC_FETCH: ok = perm[PERM_X];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tlb_rst_sync.sv
module tlb_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int N  = 64,
  parameter int KW = 20,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         ent_valid,
  input  logic [N-1:0][KW-1:0] ent_key,
  input  logic [KW-1:0]        probe,
  output logic [N-1:0]         match,
  output logic                 any,
  output logic [IW-1:0]        idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = ent_valid[g] && (ent_key[g] == probe);
  end

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tlb_slot_pick.sv
module tlb_slot_pick #(
  parameter int N = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_go,
  input  logic [N-1:0]  ent_valid,
  input  logic          dup_any,
  input  logic [IW-1:0] dup_idx,
  output logic [IW-1:0] slot_idx
);
  logic [IW-1:0] rr_q, rr_d;
  logic [IW-1:0] free_idx;
  logic          any_free;
  logic          evict;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_valid[i]) free_idx = IW'(i);
    end
  end

  assign any_free = ~&ent_valid;
  assign evict    = fill_go && !dup_any && !any_free;

  always_comb begin
    if (dup_any)       slot_idx = dup_idx;
    else if (any_free) slot_idx = free_idx;
    else               slot_idx = rr_q;
  end

  always_comb begin
    rr_d = rr_q;
    if (evict) begin
      if (rr_q == IW'(N - 1)) rr_d = '0;
      else                    rr_d = rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PFN_W     = 20,
  parameter int ENTRIES   = 64,
  localparam int VPN_W = VA_W - PAGE_BITS,
  localparam int PA_W  = PFN_W + PAGE_BITS,
  localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lookup_valid,
  input  logic [VA_W-1:0]  lookup_vaddr,
  input  logic [1:0]       lookup_kind,
  output logic             hit,
  output logic             miss,
  output logic             prot_fault,
  output logic [PA_W-1:0]  paddr,
  output logic             entry_ref,
  output logic             entry_mod,
  output logic [VPN_W-1:0] miss_vpn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [2:0]       fill_perm
);
  import tlb_pkg::*;

  logic rst_n_int;

  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0]            ref_q, ref_d;
  logic [ENTRIES-1:0]            mod_q, mod_d;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
  logic [ENTRIES-1:0][2:0]       perm_q;
  logic [VPN_W-1:0]              miss_vpn_q, miss_vpn_d;

  logic [VPN_W-1:0]     req_vpn;
  logic [PAGE_BITS-1:0] req_off;
  logic [ENTRIES-1:0]   look_match, fill_match;
  logic                 look_any, fill_any;
  logic [IW-1:0]        look_idx, fill_idx, slot_idx;
  acc_kind_e            kind;
  logic                 allowed;
  logic                 fill_wr;

  tlb_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  assign req_vpn = lookup_vaddr[VA_W-1:PAGE_BITS];
  assign req_off = lookup_vaddr[PAGE_BITS-1:0];
  assign kind    = acc_kind_e'(lookup_kind);

  tlb_cam_match #(.N(ENTRIES), .KW(VPN_W)) u_look_cam (
    .ent_valid (valid_q),
    .ent_key   (vpn_q),
    .probe     (req_vpn),
    .match     (look_match),
    .any       (look_any),
    .idx       (look_idx)
  );

  tlb_cam_match #(.N(ENTRIES), .KW(VPN_W)) u_fill_cam (
    .ent_valid (valid_q),
    .ent_key   (vpn_q),
    .probe     (fill_vpn),
    .match     (fill_match),
    .any       (fill_any),
    .idx       (fill_idx)
  );

  assign fill_wr = fill_en && !flush;

  tlb_slot_pick #(.N(ENTRIES)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .fill_go   (fill_wr),
    .ent_valid (valid_q),
    .dup_any   (fill_any),
    .dup_idx   (fill_idx),
    .slot_idx  (slot_idx)
  );

  // Outcome of the lookup, all in the request cycle.
  assign allowed    = access_ok(kind, perm_q[look_idx]);
  assign hit        = lookup_valid && look_any && allowed;
  assign prot_fault = lookup_valid && look_any && !allowed;
  assign miss       = lookup_valid && !look_any;
  assign paddr      = hit ? {pfn_q[look_idx], req_off} : '0;
  assign entry_ref  = hit && ref_q[look_idx];
  assign entry_mod  = hit && mod_q[look_idx];
  assign miss_vpn   = miss_vpn_q;

  // Next state of the flags. Flush beats refill, and refill beats the usage update.
  always_comb begin
    valid_d = valid_q;
    ref_d   = ref_q;
    mod_d   = mod_q;
    if (hit) begin
      ref_d[look_idx] = 1'b1;
      if (kind == ACC_WRITE) mod_d[look_idx] = 1'b1;
    end
    if (fill_wr) begin
      valid_d[slot_idx] = 1'b1;
      ref_d[slot_idx]   = 1'b0;
      mod_d[slot_idx]   = 1'b0;
    end
    if (flush) valid_d = '0;
  end

  always_comb begin
    miss_vpn_d = miss_vpn_q;
    if (miss) miss_vpn_d = req_vpn;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      valid_q    <= '0;
      ref_q      <= '0;
      mod_q      <= '0;
      miss_vpn_q <= '0;
    end else begin
      valid_q    <= valid_d;
      ref_q      <= ref_d;
      mod_q      <= mod_d;
      miss_vpn_q <= miss_vpn_d;
    end
  end

  // The translation payload has no reset; the valid flag guards it.
  always_ff @(posedge clk) begin
    if (fill_wr) begin
      vpn_q[slot_idx]  <= fill_vpn;
      pfn_q[slot_idx]  <= fill_pfn;
      perm_q[slot_idx] <= fill_perm;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PFN_W     = 20,
  localparam int VPN_W = VA_W - PAGE_BITS,
  localparam int PA_W  = PFN_W + PAGE_BITS
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             lookup_valid,
  input logic [VA_W-1:0]  lookup_vaddr,
  input logic [1:0]       lookup_kind,
  input logic             hit,
  input logic             miss,
  input logic             prot_fault,
  input logic [PA_W-1:0]  paddr,
  input logic [VPN_W-1:0] miss_vpn
);
  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |-> $countones({hit, miss, prot_fault}) == 1);

  assert_quiet_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |-> !(hit || miss || prot_fault));

  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> paddr[PAGE_BITS-1:0] == lookup_vaddr[PAGE_BITS-1:0]);

  assert_rsvd_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && lookup_kind == 2'd3) |-> !hit);

  assert_miss_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> miss_vpn == $past(lookup_vaddr[VA_W-1:PAGE_BITS]));

  assert_miss_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !miss |=> $stable(miss_vpn));

  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !(hit || prot_fault));
endmodule

bind tlb_xlate tlb_xlate_chk #(
  .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PFN_W(PFN_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .lookup_valid (lookup_valid),
  .lookup_vaddr (lookup_vaddr),
  .lookup_kind  (lookup_kind),
  .hit          (hit),
  .miss         (miss),
  .prot_fault   (prot_fault),
  .paddr        (paddr),
  .miss_vpn     (miss_vpn)
);

// File: tb/tlb_xlate_test.sv
`timescale 1ns/1ps
module tlb_xlate_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush, lookup_valid, fill_en;
  logic [31:0] lookup_vaddr;
  logic [1:0]  lookup_kind;
  logic        hit, miss, prot_fault, entry_ref, entry_mod;
  logic [31:0] paddr;
  logic [19:0] miss_vpn, fill_vpn, fill_pfn;
  logic [2:0]  fill_perm;

  int n_cmp = 0;
  int n_bad = 0;
  int rr_exp = 0;
  bit done = 0;

  logic        s_hit, s_miss, s_fault, s_ref, s_mod;
  logic [31:0] s_paddr;

  always #2 clk = ~clk;

  tlb_xlate #(.ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lookup_valid(lookup_valid), .lookup_vaddr(lookup_vaddr), .lookup_kind(lookup_kind),
    .hit(hit), .miss(miss), .prot_fault(prot_fault), .paddr(paddr),
    .entry_ref(entry_ref), .entry_mod(entry_mod), .miss_vpn(miss_vpn),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_perm(fill_perm)
  );

  function automatic logic [19:0] vpn_a(int i); return 20'h10000 + 20'(i) * 20'h123; endfunction
  function automatic logic [19:0] pfn_a(int i); return 20'hA0000 ^ (20'(i) * 20'h0F1); endfunction
  function automatic logic [19:0] vpn_b(int i); return 20'h30000 + 20'(i) * 20'h41; endfunction
  function automatic logic [19:0] pfn_b(int i); return 20'h50000 + 20'(i); endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    flush = 1'b0; lookup_valid = 1'b0; fill_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk); quiet();
  endtask

  task automatic look(input logic [19:0] vpn, input logic [11:0] off, input logic [1:0] kind);
    @(negedge clk); quiet();
    lookup_valid = 1'b1; lookup_vaddr = {vpn, off}; lookup_kind = kind;
    #1;
    s_hit = hit; s_miss = miss; s_fault = prot_fault;
    s_paddr = paddr; s_ref = entry_ref; s_mod = entry_mod;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [2:0] perm);
    @(negedge clk); quiet();
    fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_perm = perm;
  endtask

  task automatic do_flush();
    @(negedge clk); quiet(); flush = 1'b1;
  endtask

  task automatic expect_present(input string req, input logic [19:0] vpn, input logic [19:0] pfn);
    look(vpn, 12'h3C7, 2'd0);
    check(req, "hit", 64'(s_hit), 64'd1);
    check(req, "paddr", 64'(s_paddr), 64'({pfn, 12'h3C7}));
  endtask

  task automatic expect_absent(input string req, input logic [19:0] vpn);
    look(vpn, 12'h001, 2'd0);
    check(req, "miss", 64'(s_miss), 64'd1);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    quiet();
    lookup_vaddr = '0; lookup_kind = '0;
    fill_vpn = '0; fill_pfn = '0; fill_perm = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Reset state: R5 quiet outputs, R7 cleared capture, R3 nothing valid.
    @(negedge clk); #1;
    check("R5", "idle outcome", 64'({hit, miss, prot_fault}), 64'd0);
    check("R7", "reset miss_vpn", 64'(miss_vpn), 64'd0);
    for (int i = 0; i < N; i++) expect_absent("R3", vpn_a(i));
    look(20'h0BEEF, 12'h123, 2'd2);
    check("R3", "miss after reset", 64'(s_miss), 64'd1);
    idle();
    check("R7", "captured vpn", 64'(miss_vpn), 64'h0BEEF);

    // Fill every slot; permission value equals the slot number, giving all 8 combinations.
    for (int i = 0; i < N; i++) fill(vpn_a(i), pfn_a(i), 3'(i));

    // Sweep: slot x kind x offset (R1, R2, R4, R5).
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < 4; k++) begin
        for (int o = 0; o < 3; o++) begin
          logic [11:0] off;
          logic ok;
          off = (o == 0) ? 12'h000 : (o == 1) ? 12'hFFF : 12'h5A5;
          ok = (k < 3) && i[k];
          look(vpn_a(i), off, 2'(k));
          check("R4", "hit", 64'(s_hit), 64'(ok));
          check("R4", "prot_fault", 64'(s_fault), 64'(!ok));
          check("R2", "miss", 64'(s_miss), 64'd0);
          check("R1", "paddr", 64'(s_paddr), ok ? 64'({pfn_a(i), off}) : 64'd0);
        end
      end
    end

    // Usage flags (R6) and overwrite of a present page (R10).
    do_flush();
    fill(20'h22222, 20'h33333, 3'b111);
    look(20'h22222, 12'h010, 2'd0);
    check("R6", "ref first", 64'(s_ref), 64'd0);
    check("R6", "mod first", 64'(s_mod), 64'd0);
    look(20'h22222, 12'h010, 2'd0);
    check("R6", "ref after read", 64'(s_ref), 64'd1);
    check("R6", "mod after read", 64'(s_mod), 64'd0);
    look(20'h22222, 12'h010, 2'd1);
    check("R6", "mod before write", 64'(s_mod), 64'd0);
    look(20'h22222, 12'h010, 2'd2);
    check("R6", "mod after write", 64'(s_mod), 64'd1);

    fill(20'h44444, 20'h55555, 3'b001);
    look(20'h44444, 12'h020, 2'd1);
    check("R4", "write to read-only faults", 64'({s_fault, s_hit}), 64'b10);
    look(20'h44444, 12'h020, 2'd2);
    check("R4", "fetch to read-only faults", 64'(s_fault), 64'd1);
    look(20'h44444, 12'h020, 2'd0);
    check("R6", "fault left ref clear", 64'(s_ref), 64'd0);
    look(20'h44444, 12'h020, 2'd0);
    check("R6", "ref after read", 64'(s_ref), 64'd1);
    fill(20'h44444, 20'h66666, 3'b011);
    look(20'h44444, 12'h020, 2'd0);
    check("R10", "new frame", 64'(s_paddr), 64'h66666020);
    check("R6", "refill clears ref", 64'(s_ref), 64'd0);
    look(20'h44444, 12'h020, 2'd1);
    check("R10", "new permission", 64'(s_hit), 64'd1);
    look(20'h44444, 12'h020, 2'd0);
    check("R6", "write set mod", 64'(s_mod), 64'd1);
    expect_present("R10", 20'h22222, 20'h33333);

    // Miss capture holds across a hit (R7).
    look(20'h0ABCD, 12'h000, 2'd0);
    look(20'h22222, 12'h000, 2'd0);
    idle();
    check("R7", "held vpn", 64'(miss_vpn), 64'h0ABCD);

    // Placement and rotation (R8, R9, R10).
    do_flush();
    for (int i = 0; i < N; i++) fill(vpn_b(i), pfn_b(i), 3'b001);
    for (int i = 0; i < N; i++) expect_present("R8", vpn_b(i), pfn_b(i));
    fill(20'h7F000, 20'h00100, 3'b001);
    expect_absent("R9", vpn_b(rr_exp));
    expect_present("R9", 20'h7F000, 20'h00100);
    for (int i = 1; i < N; i++) expect_present("R9", vpn_b(i), pfn_b(i));
    rr_exp = (rr_exp + 1) % N;
    fill(20'h7F001, 20'h00101, 3'b001);
    expect_absent("R9", vpn_b(rr_exp));
    rr_exp = (rr_exp + 1) % N;
    fill(vpn_b(3), 20'h0DEAD, 3'b001);
    expect_present("R10", vpn_b(3), 20'h0DEAD);
    for (int i = 2; i < N; i++) if (i != 3) expect_present("R10", vpn_b(i), pfn_b(i));
    expect_present("R10", 20'h7F000, 20'h00100);
    expect_present("R10", 20'h7F001, 20'h00101);
    fill(20'h7F002, 20'h00102, 3'b001);
    expect_absent("R9", vpn_b(rr_exp));
    expect_present("R9", vpn_b(3), 20'h0DEAD);
    rr_exp = (rr_exp + 1) % N;

    // Flush wins over a simultaneous refill (R11).
    @(negedge clk); quiet();
    flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h7F005; fill_pfn = 20'h00105; fill_perm = 3'b001;
    expect_absent("R11", 20'h7F005);
    expect_absent("R11", 20'h7F000);
    expect_absent("R11", vpn_b(4));

    // Pointer survives the flush (R9); slots refill in order (R8).
    for (int i = 0; i < N; i++) fill(vpn_b(i), pfn_b(i), 3'b001);
    fill(20'h7F004, 20'h00104, 3'b001);
    expect_absent("R9", vpn_b(rr_exp));
    for (int i = 0; i < N; i++) if (i != rr_exp) expect_present("R8", vpn_b(i), pfn_b(i));
    idle();

    summary();
    $finish;
  end
endmodule